// File: doc/BRIEF.md
# Serial Mode-Select Command Receiver

This block receives framed commands for a display and keypad controller over a three-wire serial link: a select line, a serial clock and a data line that can change direction. While select is high, each rising edge of the serial clock moves one data bit into a 64-bit frame register. When select falls, a 4-bit mode field in the frame decides what happens to the rest of the frame. The frame can load a 60-bit display latch, load an 11-bit dimming value, choose between the analog and digital dimming sources, request a keyscan stop, or arm a key readout. Some modes do two of these things in one transfer.

When a readout is armed, the next select-high window turns the data line around. The block drives a snapshot of 30 key states out, one bit per serial clock rise. When select falls again, it returns to normal command input. All serial inputs are resynchronised into the system clock domain, so the serial clock must run well below the system clock. The serial link has no back-pressure: the host paces every bit with its own clock. The key readout is a plain shift with no valid/ready handshake.

Top module: `modesel_rx`

## Requirements
- R1: Data bits enter the frame register only on a rising serial-clock edge seen while select is high. Clock edges while select is low change nothing.
- R2: The display latch, dimming register and dimming-source flag change only in the cycle that follows a detected falling edge of select.
- R3: Frame bit n (n = 1 is the first bit sent) sits at frame index n-1. The mode field is m0..m3 = bits 49..52. On a display load, display bits 1..48 come from frame bits 1..48 and display bits 49..60 come from frame bits 53..64.
- R4: Mode 0001 loads the dimming register from frame bits 53..63, with bit 53 as the LSB. It also selects digital dimming and leaves the display latch unchanged.
- R5: Modes 0011 and 0010 select the analog source (flag 0). Modes 0101, 0100 and 0001 select the digital source (flag 1). Modes 0000, 0010, 0100 and 0110 load the display latch.
- R6: After a frame with mode 0111, 0110 or 1000, the next select-high window drives the data output enable high. In that window the block shifts out 30 key bits, key index row*6+col, index 0 first, advancing one bit per serial-clock rise. The frame register does not shift during that window.
- R7: When the readout window closes, the read strobe pulses for one cycle, the output enable drops, and the next frame is decoded as a normal command.
- R8: Modes 1000 and 1001 pulse the keyscan-stop strobe for exactly one cycle.
- R9: An unlisted mode code leaves every latch and the source flag unchanged, and the data line stays an input in the next window.
- R10: The frame register is not cleared between frames. A frame with fewer than 64 clocks is decoded from whatever the register holds when select falls.
- R11: Serial-clock edges after the 64th in one select window are ignored.
- R12: After reset the display latch and dimming register are zero, analog dimming is selected, the output enable is low, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data in |
| sdio_o | output | 1 | Serial data out (key readout) |
| sdio_oe | output | 1 | Output enable for the data line |
| key_state_i | input | 30 | Key states, index row*6+col |
| disp_o | output | 60 | Display latch |
| dim_val_o | output | 11 | Digital dimming value |
| dim_digital_o | output | 1 | 1 = digital dimming source, 0 = analog |
| scan_stop_o | output | 1 | One-cycle keyscan-stop strobe |
| scan_read_o | output | 1 | One-cycle strobe at the end of a key readout |

## Verification
The hardest state to reach from the ports is a partially shifted frame register whose contents come from two different transfers. Reaching it needs a full frame, then possibly a readout window that must not disturb the register, and then a short frame. The bench keeps its own model of the frame register, fed only by the bits it sends, and derives the expected latch contents from that model after short and over-long frames. Readout is checked by arming it with each of the three readout modes and comparing every bit shifted out against the key pattern the bench applies.

// File: rtl/modesel_pkg.sv
package modesel_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DISP_BITS  = 60;
  localparam int MODE_LSB   = 48;
  localparam int MODE_BITS  = 4;
  localparam int DIM_LSB    = MODE_LSB + MODE_BITS;
  localparam int DIM_BITS   = 11;
  localparam int DISP_LO    = MODE_LSB;
  localparam int DISP_HI    = DISP_BITS - DISP_LO;

  typedef struct packed {
    logic disp_ld;
    logic dim_ld;
    logic src_set;
    logic src_dig;
    logic readout;
    logic stop;
  } act_t;

  function automatic act_t mode_decode(input logic [MODE_BITS-1:0] m);
    act_t a;
    a = '0;
    case (m)
      4'b0000: a.disp_ld = 1'b1;
      4'b0011: a.src_set = 1'b1;
      4'b0101: begin a.src_set = 1'b1; a.src_dig = 1'b1; end
      4'b0001: begin a.dim_ld = 1'b1; a.src_set = 1'b1; a.src_dig = 1'b1; end
      4'b0111: a.readout = 1'b1;
      4'b0110: begin a.disp_ld = 1'b1; a.readout = 1'b1; end
      4'b0010: begin a.disp_ld = 1'b1; a.src_set = 1'b1; end
      4'b0100: begin a.disp_ld = 1'b1; a.src_set = 1'b1; a.src_dig = 1'b1; end
      4'b1000: begin a.readout = 1'b1; a.stop = 1'b1; end
      4'b1001: a.stop = 1'b1;
      default: a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/modesel_sync.sv
module modesel_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_prev_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_prev_o <= '0;
    else        q_prev_o <= stg[STAGES-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/modesel_shifter.sv
module modesel_shifter
  import modesel_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_i,
  input  logic                  start_i,
  input  logic                  sclk_rise_i,
  input  logic                  hold_i,
  input  logic                  bit_i,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [CW-1:0] cnt;
  logic          shift_en;

  assign shift_en = sclk_rise_i && sel_i && !hold_i && (cnt != CW'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      frame_o <= '0;
    end else if (start_i) begin
      cnt <= '0;
    end else if (shift_en) begin
      cnt     <= cnt + 1'b1;
      frame_o <= {bit_i, frame_o[FRAME_BITS-1:1]};
    end
  end

  assert_shift_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> $stable(frame_o));
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME_BITS));
endmodule

// File: rtl/modesel_unloader.sv
module modesel_unloader #(
  parameter int KEYS = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic [KEYS-1:0] keys_i,
  output logic            bit_o
);
  logic [KEYS-1:0] osr;

  always_ff @(posedge clk) begin
    if (!rst_n)      osr <= '0;
    else if (load_i) osr <= keys_i;
    else if (adv_i)  osr <= {1'b0, osr[KEYS-1:1]};
  end

  assign bit_o = osr[0];

  assert_unload_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(bit_o));
endmodule

// File: rtl/modesel_rx.sv
module modesel_rx
  import modesel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int KEY_ROWS    = 5,
  parameter int KEY_COLS    = 6,
  localparam int KEYS       = KEY_ROWS * KEY_COLS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_i,
  input  logic                 sclk_i,
  input  logic                 sdio_i,
  output logic                 sdio_o,
  output logic                 sdio_oe,
  input  logic [KEYS-1:0]      key_state_i,
  output logic [DISP_BITS-1:0] disp_o,
  output logic [DIM_BITS-1:0]  dim_val_o,
  output logic                 dim_digital_o,
  output logic                 scan_stop_o,
  output logic                 scan_read_o
);
  logic [2:0] s_now, s_prev;
  logic cs_s, cs_rise, cs_fall, sclk_rise, sd_s;
  logic rd_mode;
  logic [FRAME_BITS-1:0] frame;
  act_t act;

  modesel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_i, sclk_i, sdio_i}),
    .q_o(s_now), .q_prev_o(s_prev));

  assign cs_s      = s_now[2];
  assign cs_rise   = s_now[2] && !s_prev[2];
  assign cs_fall   = !s_now[2] && s_prev[2];
  assign sclk_rise = s_now[1] && !s_prev[1];
  assign sd_s      = s_now[0];

  modesel_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sel_i(cs_s), .start_i(cs_rise),
    .sclk_rise_i(sclk_rise), .hold_i(rd_mode), .bit_i(sd_s), .frame_o(frame));

  modesel_unloader #(.KEYS(KEYS)) u_unload (
    .clk(clk), .rst_n(rst_n), .load_i(cs_rise && rd_mode),
    .adv_i(sclk_rise && cs_s && rd_mode), .keys_i(key_state_i), .bit_o(sdio_o));

  assign act     = mode_decode(frame[MODE_LSB +: MODE_BITS]);
  assign sdio_oe = rd_mode && cs_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_o        <= '0;
      dim_val_o     <= '0;
      dim_digital_o <= 1'b0;
      rd_mode       <= 1'b0;
      scan_stop_o   <= 1'b0;
      scan_read_o   <= 1'b0;
    end else begin
      scan_stop_o <= 1'b0;
      scan_read_o <= 1'b0;
      if (cs_fall) begin
        if (rd_mode) begin
          rd_mode     <= 1'b0;
          scan_read_o <= 1'b1;
        end else begin
          rd_mode     <= act.readout;
          scan_stop_o <= act.stop;
          if (act.disp_ld)
            disp_o <= {frame[FRAME_BITS-1 -: DISP_HI], frame[DISP_LO-1:0]};
          if (act.dim_ld)
            dim_val_o <= frame[DIM_LSB +: DIM_BITS];
          if (act.src_set)
            dim_digital_o <= act.src_dig;
        end
      end
    end
  end

  assert_disp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(disp_o));
  assert_dim_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> ($stable(dim_val_o) && $stable(dim_digital_o)));
  assert_frame_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && cs_s) |=> $stable(frame));
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_stop_o, scan_read_o}));
endmodule

// File: tb/modesel_rx_bench.sv
module modesel_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, oe, dig, stp, rdd;
  logic [29:0] keys = '0;
  logic [59:0] disp;
  logic [10:0] dim;

  int n_tests = 0, n_fail = 0, n_stop = 0, n_read = 0;
  logic [63:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modesel_rx u_modesel_rx (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe(oe), .key_state_i(keys), .disp_o(disp),
    .dim_val_o(dim), .dim_digital_o(dig), .scan_stop_o(stp), .scan_read_o(rdd));

  always @(posedge clk) begin
    if (stp) n_stop++;
    if (rdd) n_read++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] mk_disp(input logic [3:0] m, input logic [59:0] d);
    return {d[59:48], m, d[47:0]};
  endfunction

  function automatic logic [63:0] mk_dim(input logic [3:0] m, input logic [10:0] v);
    return {1'b0, v, m, 48'h0};
  endfunction

  function automatic logic [59:0] disp_of(input logic [63:0] f);
    return {f[63:52], f[47:0]};
  endfunction

  // sends n bits of f, LSB first; model follows R1/R10/R11
  task automatic send(input logic [63:0] f, input int n);
    cs = 1'b1; wclk(HALF + 2);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 64) ? f[i] : 1'b1;
      wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0;
      if (i < 64) model = {sdi, model[63:1]};
    end
    wclk(HALF); cs = 1'b0; wclk(8);
  endtask

  task automatic readout(input logic [29:0] k, input string tag);
    logic [29:0] got;
    keys = k; cs = 1'b1; wclk(HALF + 4);
    chk(oe === 1'b1, {tag, " R6 oe in window"}, 64'(oe), 64'd1);
    for (int i = 0; i < 30; i++) begin
      got[i] = sdo;
      sdi = ~sdi; wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0; wclk(HALF);
    end
    chk(got === k, {tag, " R6 key bits"}, 64'(got), 64'(k));
    cs = 1'b0; wclk(8);
    chk(oe === 1'b0, {tag, " R7 oe released"}, 64'(oe), 64'd0);
  endtask

  task automatic t_reset();
    chk(disp === '0 && dim === '0, "R12 latches clear", {disp[52:0], dim}, 64'd0);
    chk(dig === 1'b0 && oe === 1'b0 && stp === 1'b0 && rdd === 1'b0, "R12 flags",
        64'({dig, oe, stp, rdd}), 64'd0);
  endtask

  task automatic t_display();
    logic [59:0] d = 60'hA5C_3F01_2345_6789;
    wclk(3); sclk = 1'b1; wclk(3); sclk = 1'b0; sdi = 1'b1; wclk(3); // clocks with select low
    chk(disp === '0, "R1 idle clocks ignored", 64'(disp), 64'd0);
    send(mk_disp(4'b0000, d), 64);
    chk(disp === d, "R3 display frame", 64'(disp), 64'(d));
    chk(dig === 1'b0, "R5 0000 keeps source", 64'(dig), 64'd0);
  endtask

  task automatic t_dimming();
    logic [59:0] d0 = disp;
    send(mk_dim(4'b0001, 11'h5B3), 64);
    chk(dim === 11'h5B3, "R4 dimming value", 64'(dim), 64'h5B3);
    chk(dig === 1'b1, "R4 selects digital", 64'(dig), 64'd1);
    chk(disp === d0, "R4 display untouched", 64'(disp), 64'(d0));
  endtask

  task automatic t_sources();
    logic [59:0] d = 60'h0F0_F0F0_F0F0_1234;
    send(mk_disp(4'b0011, 60'h1), 64);
    chk(dig === 1'b0 && disp !== 60'h1, "R5 0011 analog only", 64'(dig), 64'd0);
    send(mk_disp(4'b0101, 60'h2), 64);
    chk(dig === 1'b1 && disp !== 60'h2, "R5 0101 digital only", 64'(dig), 64'd1);
    send(mk_disp(4'b0010, d), 64);
    chk(dig === 1'b0 && disp === d, "R5 0010 display+analog", 64'(disp), 64'(d));
    send(mk_disp(4'b0100, ~d), 64);
    chk(dig === 1'b1 && disp === ~d, "R5 0100 display+digital", 64'(disp), 64'(~d));
    chk(dim === 11'h5B3, "R2 dim kept", 64'(dim), 64'h5B3);
  endtask

  task automatic t_keyscan();
    int s0, r0;
    logic [59:0] d = 60'h123_4567_89AB_CDEF;
    logic [63:0] m0;
    s0 = n_stop; r0 = n_read;
    send(mk_disp(4'b0111, 60'h0), 64);
    m0 = model;
    readout(30'h2A5C3B19, "0111");
    chk(model === m0 && n_read == r0 + 1, "R7 read strobe once", 64'(n_read - r0), 64'd1);
    send(mk_disp(4'b0110, d), 64);
    chk(disp === d, "R5 0110 loads display", 64'(disp), 64'(d));
    readout(30'h15A3C4E6, "0110");
    send(mk_disp(4'b1000, 60'h0), 64);
    chk(n_stop == s0 + 1, "R8 1000 stop strobe", 64'(n_stop - s0), 64'd1);
    readout(30'h3FFF0001, "1000");
    send(mk_disp(4'b1001, 60'h0), 64);
    chk(n_stop == s0 + 2, "R8 1001 stop strobe", 64'(n_stop - s0), 64'd2);
    cs = 1'b1; wclk(HALF + 4);
    chk(oe === 1'b0, "R8 1001 no readout", 64'(oe), 64'd0);
    cs = 1'b0; wclk(8);
    send(mk_disp(4'b0000, ~d), 64);
    chk(disp === ~d, "R7 normal after readout", 64'(disp), 64'(~d));
  endtask

  task automatic t_unlisted();
    logic [59:0] d0 = disp;
    logic [10:0] v0 = dim;
    logic g0 = dig;
    send(mk_dim(4'b1111, 11'h7FF), 64);
    chk(disp === d0 && dim === v0 && dig === g0, "R9 unlisted no change", 64'(dim), 64'(v0));
    cs = 1'b1; wclk(HALF + 4);
    chk(oe === 1'b0, "R9 pin stays input", 64'(oe), 64'd0);
    cs = 1'b0; wclk(8);
  endtask

  task automatic t_short_long();
    logic [59:0] d = 60'h9E1_0C0F_FEE0_7711;
    send(mk_disp(4'b0000, d), 64);
    send(64'h0000_0000_0000_ABC0, 16);
    chk(model[51:48] === 4'b0000 && disp === disp_of(model), "R10 short frame",
        64'(disp), 64'(disp_of(model)));
    send(mk_disp(4'b0000, ~d), 70);
    chk(disp === ~d, "R11 extra clocks ignored", 64'(disp), 64'(~d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wclk(5); rst_n = 1'b1; wclk(3);
    t_reset();
    t_display();
    t_dimming();
    t_sources();
    t_keyscan();
    t_unlisted();
    t_short_long();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule